// File: doc/BRIEF.md
# Trigger distributor with busy lockout

This block merges two external trigger inputs and an internal periodic oscillator into one trigger. It sends that trigger to eight front-end outputs, and each output has its own enable. A busy flag stops further triggers after the first one. The busy flag stays set until software writes it back to zero, so each trigger that gets through can be read out before the next one is accepted. A burst mode replaces the normal trigger sources with an exact number of generated pulses. These pulses are spaced by the oscillator period.

A simple register bus controls the block and reports its state. Writes take effect at the clock edge. Reads are combinational from the address. Two counters record trigger edges: one before the busy gate and one after it. A status word shows the live level of each stage of the trigger path. A catch word remembers every stage that has been high since software last cleared it. The timing assumes a 40 MHz clock (25 ns per oscillator step).

Top module: `trigger_distributor`

## Requirements
- R1: After reset the following hold:
  - busy reads 0 and the enable register reads 0.
  - The output enable register reads 0x000000FF.
  - Both counters, the period register and the burst register read 0.
  - `fe_trig` is 0.
- R2: The trigger enable register is at 0x04. Bit 0 admits external input 0, bit 1 admits external input 1, and bit 24 admits the oscillator. A source whose bit is 0 never produces a front-end pulse.
- R3: External inputs are registered once. A rising edge of the merged, enabled trigger while busy is clear does two things:
  - It produces a one-cycle pulse on the enabled outputs. The pulse appears after the second clock edge following the input change.
  - It sets busy (bit 0 of 0x00) in that same cycle.
- R4: While busy is set, no normal trigger edge reaches `fe_trig`. A write to 0x00 with bit 0 = 0 clears busy, and a write with bit 0 = 1 leaves it unchanged. If a trigger passes in the same cycle as the clearing write, setting busy wins.
- R5: The output enable register is at 0x10. Bits 0..7 gate outputs 0..7, and a pulse appears only on outputs whose bit is 1.
- R6: The oscillator period register is at 0x18 and counts clock cycles. With a value P > 0, the oscillator gives a one-cycle pulse every P cycles. The first pulse comes P edges after the write edge. Any write restarts the count, and P = 0 stops the pulses.
- R7: The burst register is at 0x1C, and a write loads all of its fields:
  - Bits 15:0 hold the pulse count.
  - Bit 16 selects burst mode. Burst mode blocks all normal sources.
  - Bit 17 starts a burst, but only if bit 16 is also written as 1.
  - The burst emits exactly the count of one-cycle pulses, one on each oscillator pulse. These pulses ignore busy and do not set it.
  - Bit 17 reads 0 once the last pulse has been sent.
- R8: The counter at 0x14 counts pulses sent to the outputs. The counter at 0x30 counts rising edges of the merged trigger before the busy gate, plus burst pulses. A write of any value to either address clears that counter.
- R9: The status word at 0x08 has these bits:
  - bits 0 and 1: raw registered inputs
  - bits 8 and 9: inputs after their enable bits
  - bit 16: merged trigger before the busy gate
  - bit 17: pulse being sent this cycle
  - bit 24: oscillator pulse
- R10: The catch word at 0x0C uses the same bit layout as the status word. A catch bit becomes 1 in any cycle where its status bit is 1, and it stays 1. A write clears every catch bit whose write-data bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 40 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | N_EXT (2) | External trigger levels, already synchronous to clk |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fe_trig | output | N_OUT (8) | Front-end trigger pulses |

## Verification
The assertions check these properties on every cycle:
- A set busy flag keeps `fe_trig` quiet in normal mode.
- Every normal pulse that passes sets busy.
- No output fires unless its enable bit was set.
- The oscillator pulse is one cycle wide whenever the period exceeds one.
- The pre-busy counter never advances by more than one per cycle.

Only the directed scenarios can show the following:
- the two-edge latency
- the exact oscillator spacing and restart on write
- the exact pulse count of a burst and its self-clearing start bit
- the selective clearing of catch bits
- the effect of the enable bits on each source

// File: rtl/trig_dist_pkg.sv
package trig_dist_pkg;

    localparam int ADDR_W = 8;

    // register byte addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_TEN    = 8'h04;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h08;
    localparam logic [ADDR_W-1:0] A_CATCH  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_OEN    = 8'h10;
    localparam logic [ADDR_W-1:0] A_POST   = 8'h14;
    localparam logic [ADDR_W-1:0] A_PERIOD = 8'h18;
    localparam logic [ADDR_W-1:0] A_BURST  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_PRE    = 8'h30;

    // bit positions shared by status, catch and enable words
    localparam int B_EXT_RAW = 0;
    localparam int B_EXT_EN  = 8;
    localparam int B_PRE     = 16;
    localparam int B_SENT    = 17;
    localparam int B_OSC     = 24;

    // burst register flags
    localparam int B_BURST_MODE = 16;
    localparam int B_BURST_GO   = 17;

endpackage

// File: rtl/trig_osc.sv
// Periodic one-cycle pulse generator (R6).
module trig_osc #(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic                pulse
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                pulse;
    } osc_t;

    osc_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (restart || period == '0) begin
            d.cnt = '0;
        end else if (q.cnt >= period - PERIOD_W'(1)) begin
            d.cnt   = '0;
            d.pulse = 1'b1;
        end else begin
            d.cnt = q.cnt + PERIOD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = q.pulse;

endmodule

// File: rtl/trig_burst.sv
// Burst sequencer: counts out a programmed number of pulses on oscillator ticks (R7).
module trig_burst #(
    parameter int BURST_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [BURST_W-1:0] cfg_count,
    input  logic               cfg_mode,
    input  logic               cfg_go,
    input  logic               tick,
    output logic               mode,
    output logic               go,
    output logic [BURST_W-1:0] count,
    output logic               pulse
);

    typedef struct packed {
        logic [BURST_W-1:0] count;
        logic [BURST_W-1:0] remain;
        logic               mode;
        logic               go;
    } burst_t;

    burst_t q, d;

    assign pulse = q.mode && q.go && tick && (q.remain != '0);

    always_comb begin
        d = q;
        if (pulse) begin
            d.remain = q.remain - BURST_W'(1);
            if (q.remain == BURST_W'(1)) d.go = 1'b0;
        end else if (q.go && q.remain == '0) begin
            d.go = 1'b0;
        end
        if (cfg_wr) begin
            d.count  = cfg_count;
            d.remain = cfg_count;
            d.mode   = cfg_mode;
            d.go     = cfg_go && cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode  = q.mode;
    assign go    = q.go;
    assign count = q.count;

endmodule

// File: rtl/trig_event_counter.sv
// Event counter with synchronous clear on write (R8).
module trig_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

endmodule

// File: rtl/trigger_distributor.sv
module trigger_distributor
    import trig_dist_pkg::*;
#(
    parameter int N_EXT    = 2,
    parameter int N_OUT    = 8,
    parameter int PERIOD_W = 32,
    parameter int BURST_W  = 16,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_trig,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_OUT-1:0]  fe_trig
);

    localparam logic [N_OUT-1:0] OEN_RESET = '1;

    typedef struct packed {
        logic                busy;
        logic [N_EXT-1:0]    ext;
        logic                raw_prev;
        logic [N_EXT-1:0]    en_ext;
        logic                en_osc;
        logic [N_OUT-1:0]    oen;
        logic [PERIOD_W-1:0] period;
        logic [31:0]         catches;
        logic [N_OUT-1:0]    fe;
    } dist_t;

    dist_t q, d;

    // register write strobes
    logic wr_ctrl, wr_ten, wr_catch, wr_oen, wr_post, wr_period, wr_burst, wr_pre;
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_ten    = bus_wr && (bus_addr == A_TEN);
    assign wr_catch  = bus_wr && (bus_addr == A_CATCH);
    assign wr_oen    = bus_wr && (bus_addr == A_OEN);
    assign wr_post   = bus_wr && (bus_addr == A_POST);
    assign wr_period = bus_wr && (bus_addr == A_PERIOD);
    assign wr_burst  = bus_wr && (bus_addr == A_BURST);
    assign wr_pre    = bus_wr && (bus_addr == A_PRE);

    // sub-blocks
    logic               osc_pulse;
    logic               burst_mode, burst_go, burst_pulse;
    logic [BURST_W-1:0] burst_count;
    logic [CNT_W-1:0]   post_cnt, pre_cnt;

    trig_osc #(.PERIOD_W(PERIOD_W)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (q.period),
        .restart (wr_period),
        .pulse   (osc_pulse)
    );

    trig_burst #(.BURST_W(BURST_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_burst),
        .cfg_count (bus_wdata[BURST_W-1:0]),
        .cfg_mode  (bus_wdata[B_BURST_MODE]),
        .cfg_go    (bus_wdata[B_BURST_GO]),
        .tick      (osc_pulse),
        .mode      (burst_mode),
        .go        (burst_go),
        .count     (burst_count),
        .pulse     (burst_pulse)
    );

    // merge, edge detect, busy gate (R2, R3, R4, R7)
    logic [N_EXT-1:0] ext_gated;
    logic norm_raw, raw, rise, sent, pre_inc;

    assign ext_gated = q.ext & q.en_ext;
    assign norm_raw  = (|ext_gated) || (osc_pulse && q.en_osc);
    assign raw       = burst_mode ? burst_pulse : norm_raw;
    assign rise      = norm_raw && !q.raw_prev;
    assign sent      = burst_mode ? burst_pulse : (rise && !q.busy);
    assign pre_inc   = burst_mode ? burst_pulse : rise;

    trig_event_counter #(.CNT_W(CNT_W)) u_post_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_post),
        .inc   (sent),
        .value (post_cnt)
    );

    trig_event_counter #(.CNT_W(CNT_W)) u_pre_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_pre),
        .inc   (pre_inc),
        .value (pre_cnt)
    );

    // live status word (R9)
    logic [31:0] status;
    always_comb begin
        status = '0;
        status[B_EXT_RAW +: N_EXT] = q.ext;
        status[B_EXT_EN  +: N_EXT] = ext_gated;
        status[B_PRE]              = raw;
        status[B_SENT]             = sent;
        status[B_OSC]              = osc_pulse;
    end

    // next state
    always_comb begin
        d          = q;
        d.ext      = ext_trig;
        d.raw_prev = norm_raw;
        d.fe       = sent ? q.oen : '0;

        if (wr_ctrl && !bus_wdata[0]) d.busy = 1'b0;
        if (sent && !burst_mode)      d.busy = 1'b1;

        if (wr_ten) begin
            d.en_ext = bus_wdata[N_EXT-1:0];
            d.en_osc = bus_wdata[B_OSC];
        end
        if (wr_oen)    d.oen    = bus_wdata[N_OUT-1:0];
        if (wr_period) d.period = bus_wdata[PERIOD_W-1:0];

        d.catches = (wr_catch ? (q.catches & bus_wdata) : q.catches) | status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.oen <= OEN_RESET;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata[0] = q.busy;
            A_TEN: begin
                bus_rdata[N_EXT-1:0] = q.en_ext;
                bus_rdata[B_OSC]     = q.en_osc;
            end
            A_STAT:   bus_rdata = status;
            A_CATCH:  bus_rdata = q.catches;
            A_OEN:    bus_rdata[N_OUT-1:0] = q.oen;
            A_POST:   bus_rdata[CNT_W-1:0] = post_cnt;
            A_PERIOD: bus_rdata[PERIOD_W-1:0] = q.period;
            A_BURST: begin
                bus_rdata[BURST_W-1:0]  = burst_count;
                bus_rdata[B_BURST_MODE] = burst_mode;
                bus_rdata[B_BURST_GO]   = burst_go;
            end
            A_PRE:    bus_rdata[CNT_W-1:0] = pre_cnt;
            default:  bus_rdata = '0;
        endcase
    end

    assign fe_trig = q.fe;

endmodule

// File: rtl/trig_dist_checker.sv
module trig_dist_checker #(
    parameter int N_OUT    = 8,
    parameter int PERIOD_W = 32,
    parameter int CNT_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                burst_mode,
    input logic                sent,
    input logic [N_OUT-1:0]    fe_trig,
    input logic [N_OUT-1:0]    oen,
    input logic                osc_pulse,
    input logic [PERIOD_W-1:0] period,
    input logic                period_wr,
    input logic                pre_clr,
    input logic [CNT_W-1:0]    pre_cnt
);

    // R4: a held busy flag silences the outputs in normal mode
    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !burst_mode) |=> (fe_trig == '0));

    // R3: a normal pulse that passes leaves busy set
    p_busy_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sent && !burst_mode) |=> busy);

    // R5: no output fires without its enable bit
    p_oen_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fe_trig & ~$past(oen)) == '0));

    // R6: oscillator pulse is one cycle wide
    p_osc_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_pulse && period > PERIOD_W'(1) && !period_wr) |=> !osc_pulse);

    // R8: pre-busy counter advances at most one per cycle
    p_pre_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_clr |=> ((pre_cnt - $past(pre_cnt)) <= CNT_W'(1)));

endmodule

bind trigger_distributor trig_dist_checker #(
    .N_OUT    (N_OUT),
    .PERIOD_W (PERIOD_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (q.busy),
    .burst_mode (burst_mode),
    .sent       (sent),
    .fe_trig    (fe_trig),
    .oen        (q.oen),
    .osc_pulse  (osc_pulse),
    .period     (q.period),
    .period_wr  (wr_period),
    .pre_clr    (wr_pre),
    .pre_cnt    (pre_cnt)
);

// File: tb/trigger_distributor_bench.sv
module trigger_distributor_bench;

    localparam int CLK_P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_trig = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  fe_trig;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    trigger_distributor u_trigger_distributor (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_trig  (ext_trig),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fe_trig   (fe_trig)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1", "busy", v, 32'h0);
        rd(8'h04, v); check("R1", "enables", v, 32'h0);
        rd(8'h10, v); check("R1", "output enables", v, 32'hFF);
        rd(8'h14, v); check("R1", "post counter", v, 32'h0);
        rd(8'h30, v); check("R1", "pre counter", v, 32'h0);
        rd(8'h18, v); check("R1", "period", v, 32'h0);
        rd(8'h1C, v); check("R1", "burst", v, 32'h0);
        check("R1", "fe_trig", 32'(fe_trig), 32'h0);
    endtask

    task automatic t_trigger_busy();
        logic [31:0] v;
        wr(8'h04, 32'h1);
        wr(8'h14, 32'h0);
        wr(8'h30, 32'h0);
        ext_trig = 2'b01;
        step();
        rd(8'h08, v); check("R9", "status at pass", v & 32'h0303_0303, 32'h0003_0101);
        step();
        check("R3", "first edge output", 32'(fe_trig), 32'hFF);
        rd(8'h00, v); check("R3", "busy set", v, 32'h1);
        step();
        check("R3", "one cycle wide", 32'(fe_trig), 32'h0);
        ext_trig = 2'b00;
        step(2);
        ext_trig = 2'b01;
        step(2);
        check("R4", "blocked while busy", 32'(fe_trig), 32'h0);
        ext_trig = 2'b00;
        step();
        rd(8'h30, v); check("R8", "pre-busy count", v, 32'd2);
        rd(8'h14, v); check("R8", "sent count", v, 32'd1);
        wr(8'h00, 32'h1);
        rd(8'h00, v); check("R4", "write one keeps busy", v, 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R4", "write zero clears busy", v, 32'h0);
        ext_trig = 2'b01;
        step(2);
        check("R4", "passes after clear", 32'(fe_trig), 32'hFF);
        ext_trig = 2'b00;
        step();
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h5);
        rd(8'h14, v); check("R8", "write clears counter", v, 32'h0);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(8'h04, 32'h0);
        ext_trig = 2'b11;
        step(2);
        check("R2", "both disabled", 32'(fe_trig), 32'h0);
        rd(8'h08, v); check("R9", "raw vs gated", v & 32'h0000_0303, 32'h0000_0003);
        ext_trig = 2'b00;
        step();
        wr(8'h04, 32'h2);
        ext_trig = 2'b10;
        step(2);
        check("R2", "input 1 enabled", 32'(fe_trig), 32'hFF);
        ext_trig = 2'b00;
        step();
        wr(8'h00, 32'h0);
        ext_trig = 2'b01;
        step(2);
        check("R2", "input 0 disabled", 32'(fe_trig), 32'h0);
        ext_trig = 2'b00;
        step();
    endtask

    task automatic t_output_enables();
        wr(8'h10, 32'h5A);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h0);
        ext_trig = 2'b01;
        step(2);
        check("R5", "masked fan-out", 32'(fe_trig), 32'h5A);
        ext_trig = 2'b00;
        step();
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hFF);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_osc();
        logic [31:0] v;
        int cnt;
        int first;
        wr(8'h18, 32'd5);
        step(3);
        wr(8'h18, 32'd5);
        cnt = 0;
        first = 0;
        for (int i = 1; i <= 40; i++) begin
            step();
            rd(8'h08, v);
            if (v[24]) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
        check("R6", "first pulse after restart", 32'(first), 32'd5);
        check("R6", "pulses in 40 cycles", 32'(cnt), 32'd8);
        wr(8'h18, 32'd0);
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            step();
            rd(8'h08, v);
            if (v[24]) cnt++;
        end
        check("R6", "period zero stops", 32'(cnt), 32'd0);
        wr(8'h04, 32'h0100_0000);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'd6);
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            step();
            if (fe_trig != 8'h0) cnt++;
        end
        check("R2", "oscillator routed once then busy", 32'(cnt), 32'd1);
        wr(8'h18, 32'd0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        int cnt;
        wr(8'h04, 32'h0100_0001);
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'd4);
        wr(8'h1C, 32'h0003_0003);
        cnt = 0;
        for (int i = 1; i <= 40; i++) begin
            if (i == 10) ext_trig = 2'b01;
            if (i == 12) ext_trig = 2'b00;
            step();
            if (fe_trig != 8'h0) cnt++;
        end
        check("R7", "burst pulse count", 32'(cnt), 32'd3);
        rd(8'h1C, v); check("R7", "start bit self-clears", v, 32'h0001_0003);
        rd(8'h14, v); check("R8", "sent count in burst", v, 32'd3);
        rd(8'h00, v); check("R7", "burst leaves busy clear", v, 32'h0);
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            if (i == 5) ext_trig = 2'b01;
            if (i == 7) ext_trig = 2'b00;
            step();
            if (fe_trig != 8'h0) cnt++;
        end
        check("R7", "mode blocks normal triggers", 32'(cnt), 32'd0);
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        step(2);
    endtask

    task automatic t_catch();
        logic [31:0] v;
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); check("R10", "cleared", v, 32'h0);
        ext_trig = 2'b01;
        step();
        ext_trig = 2'b00;
        step(2);
        rd(8'h0C, v); check("R10", "raw caught, gated not", v, 32'h0000_0001);
        wr(8'h0C, 32'hFFFF_FFFE);
        rd(8'h0C, v); check("R10", "selective clear", v, 32'h0);
        wr(8'h04, 32'h1);
        ext_trig = 2'b01;
        step();
        ext_trig = 2'b00;
        step(2);
        rd(8'h0C, v); check("R10", "full path caught", v, 32'h0003_0101);
        wr(8'h00, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_trigger_busy();
        t_enables();
        t_output_enables();
        t_osc();
        t_burst();
        t_catch();
        finish_run();
    end

endmodule